// File: doc/BRIEF.md
# Interpolating Table Waveshaper

This block remaps each signed fixed-point sample `x` to `f(x)`. The function is held as a table of `L` points spread evenly across the whole signed input range. The top address bits of the sample select a table entry. The remaining low bits act as a fraction between that entry and its upper neighbour. The output is the straight-line blend of the two entries. The block can stand in for soft clipping, log or exponential remapping, or any other stateless curve whose table image is fixed at elaboration.

Samples arrive and leave on valid/ready streams. A transfer happens on a rising edge where both valid and ready are high. The input is ready exactly when the output register is empty, or when the consumer is taking its contents in the same cycle. A stalled consumer therefore freezes the whole three-stage pipeline. A held output keeps its value until it is taken. Each sample carries a wrap flag. The flag picks how the last table segment behaves: it either holds flat at the top entry, or it blends back toward entry 0 so that a sawtooth input gives a continuous output.

Top module: `lutshape`

## Requirements
- R1: The table has `L = 2**AW` entries (default 512, data width DW = 16). Entry k holds the low DW bits of 5k² + 3k − 20000, read as two's complement. The offset value u = x + 2^(DW−1) is split into an address, made of the top AW bits of u, and a fraction, made of the low FW = DW − AW bits of u.
- R2: When the fraction is zero, the output equals the addressed entry exactly.
- R3: Otherwise the output is y = T[a] + floor((frac·(T[hi] − T[a]) + 2^(FW−1)) / 2^FW), with hi = a + 1 below the top entry.
- R4: With the wrap flag low and the address at L−1, the upper neighbour is T[L−1], so the output is clamped to T[L−1].
- R5: With the wrap flag high and the address at L−1, the upper neighbour is T[0].
- R6: Exactly one output is produced for each accepted input, in order. An output never appears without a pending input.
- R7: With the output ready held high, a sample accepted on one rising edge shows as valid output after the second rising edge that follows.
- R8: i_ready equals (!o_valid || o_ready). While o_valid is high and o_ready is low, o_valid stays high and o_y stays stable.
- R9: While rst is high, o_valid is cleared, and i_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Input sample valid |
| i_ready | output | 1 | Block can take an input sample |
| i_x | input | DW | Signed input sample |
| i_wrap | input | 1 | Wrap flag travelling with the sample: last segment blends toward entry 0 |
| o_valid | output | 1 | Output sample valid |
| o_ready | input | 1 | Consumer takes the output sample |
| o_y | output | DW | Signed shaped output sample |

## Verification
The bench drives the range ends. The most negative input must return T[0] untouched; a sign-flip mistake in the address offset would return the entry from the middle of the table instead. The most positive input is sent with both wrap settings. If the upper-neighbour select is wrong, the clamped case drifts toward T[0], or the wrapping case stays flat. Half-way fractions exercise the rounding offset, and negative slopes expose a logical shift used in place of an arithmetic one. Random consumer stalls check that a held output neither changes nor gets lost or duplicated, and that the stream ends with nothing still owed.

// File: rtl/lutshape_pkg.sv
package lutshape_pkg;
  // Table image generator: value at index k before truncation to the data width.
  function automatic int lut_point(int k);
    return 5 * k * k + 3 * k - 20000;
  endfunction
endpackage

// File: rtl/lutshape_addr.sv
module lutshape_addr #(
  parameter int DW = 16,
  parameter int AW = 9,
  localparam int FW = DW - AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_x,
  input  logic          in_wrap,
  output logic          s1_valid,
  output logic [AW-1:0] s1_addr,
  output logic [FW-1:0] s1_frac,
  output logic          s1_wrap
);
  // Offset-binary view of the sample: flip the sign bit.
  logic [DW-1:0] ubias;
  assign ubias = {~in_x[DW-1], in_x[DW-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (en) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_addr <= ubias[DW-1:FW];
      s1_frac <= ubias[FW-1:0];
      s1_wrap <= in_wrap;
    end
  end
endmodule

// File: rtl/lutshape_rom.sv
module lutshape_rom #(
  parameter int DW = 16,
  parameter int AW = 9,
  localparam int FW = DW - AW,
  localparam int L  = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          s1_valid,
  input  logic [AW-1:0] s1_addr,
  input  logic [FW-1:0] s1_frac,
  input  logic          s1_wrap,
  output logic          s2_valid,
  output logic [DW-1:0] s2_lo,
  output logic [DW-1:0] s2_hi,
  output logic [FW-1:0] s2_frac
);
  import lutshape_pkg::*;

  logic [DW-1:0] table_mem [L];

  initial begin
    for (int k = 0; k < L; k++) begin
      table_mem[k] = DW'(lut_point(k));
    end
  end

  // Upper neighbour: next entry, or at the top either itself or entry 0.
  logic          at_top;
  logic [AW-1:0] hi_addr;
  assign at_top  = &s1_addr;
  assign hi_addr = at_top ? (s1_wrap ? '0 : s1_addr) : s1_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
    end else if (en) begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s2_lo   <= table_mem[s1_addr];
      s2_hi   <= table_mem[hi_addr];
      s2_frac <= s1_frac;
    end
  end
endmodule

// File: rtl/lutshape_interp.sv
module lutshape_interp #(
  parameter int DW = 16,
  parameter int FW = 7,
  localparam int PW = DW + FW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          s2_valid,
  input  logic [DW-1:0] s2_lo,
  input  logic [DW-1:0] s2_hi,
  input  logic [FW-1:0] s2_frac,
  output logic          o_valid,
  output logic [DW-1:0] o_y
);
  localparam logic signed [PW-1:0] HALF = PW'(1 << (FW - 1));

  logic signed [DW:0]   slope;
  logic signed [FW:0]   frac_s;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] step;
  logic signed [PW-1:0] base;

  assign slope  = $signed({s2_hi[DW-1], s2_hi}) - $signed({s2_lo[DW-1], s2_lo});
  assign frac_s = $signed({1'b0, s2_frac});
  assign prod   = slope * frac_s + HALF;
  assign step   = prod >>> FW;
  assign base   = PW'($signed(s2_lo));

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
    end else if (en) begin
      o_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en && s2_valid) begin
      o_y <= DW'(base + step);
    end
  end
endmodule

// File: rtl/lutshape.sv
module lutshape #(
  parameter int DW = 16,
  parameter int AW = 9,
  localparam int FW = DW - AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          i_valid,
  output logic          i_ready,
  input  logic [DW-1:0] i_x,
  input  logic          i_wrap,
  output logic          o_valid,
  input  logic          o_ready,
  output logic [DW-1:0] o_y
);
  logic          advance;
  logic          s1_valid, s1_wrap, s2_valid;
  logic [AW-1:0] s1_addr;
  logic [FW-1:0] s1_frac, s2_frac;
  logic [DW-1:0] s2_lo, s2_hi;

  // Whole pipeline moves only when the output register can be refilled.
  assign advance = !o_valid || o_ready;
  assign i_ready = advance;

  lutshape_addr #(.DW(DW), .AW(AW)) u_addr (
    .clk(clk), .rst(rst), .en(advance),
    .in_valid(i_valid), .in_x(i_x), .in_wrap(i_wrap),
    .s1_valid(s1_valid), .s1_addr(s1_addr), .s1_frac(s1_frac), .s1_wrap(s1_wrap)
  );

  lutshape_rom #(.DW(DW), .AW(AW)) u_rom (
    .clk(clk), .rst(rst), .en(advance),
    .s1_valid(s1_valid), .s1_addr(s1_addr), .s1_frac(s1_frac), .s1_wrap(s1_wrap),
    .s2_valid(s2_valid), .s2_lo(s2_lo), .s2_hi(s2_hi), .s2_frac(s2_frac)
  );

  lutshape_interp #(.DW(DW), .FW(FW)) u_interp (
    .clk(clk), .rst(rst), .en(advance),
    .s2_valid(s2_valid), .s2_lo(s2_lo), .s2_hi(s2_hi), .s2_frac(s2_frac),
    .o_valid(o_valid), .o_y(o_y)
  );
endmodule

// File: rtl/lutshape_chk.sv
module lutshape_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          i_valid,
  input logic          i_ready,
  input logic          o_valid,
  input logic          o_ready,
  input logic [DW-1:0] o_y
);
  // Samples accepted but not yet delivered.
  logic [3:0] pending;
  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else pending <= pending + 4'(i_valid && i_ready) - 4'(o_valid && o_ready);
  end

  a_r9_reset_clear: assert property (@(posedge clk) rst |=> !o_valid);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_y)));

  a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |-> !i_ready);

  a_r6_no_spurious_output: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (pending != 4'd0));

  a_r6_bounded_inflight: assert property (@(posedge clk) disable iff (rst)
    pending <= 4'd3);
endmodule

bind lutshape lutshape_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .i_valid(i_valid), .i_ready(i_ready),
  .o_valid(o_valid), .o_ready(o_ready), .o_y(o_y)
);

// File: tb/lutshape_test.sv
module lutshape_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 9;
  localparam int FW = DW - AW;
  localparam int L  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_valid = 1'b0, i_wrap = 1'b0, o_ready = 1'b0;
  logic [DW-1:0] i_x = '0;
  logic i_ready, o_valid;
  logic [DW-1:0] o_y;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lutshape uut (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_ready(i_ready),
    .i_x(i_x), .i_wrap(i_wrap), .o_valid(o_valid), .o_ready(o_ready), .o_y(o_y)
  );

  int checks = 0;
  int fails  = 0;
  int expq[$];
  string tagq[$];
  bit prev_stall = 0;
  logic [DW-1:0] prev_y;
  bit cap_ov;

  function automatic int tval(int k);
    int v;
    v = (5 * k * k + 3 * k - 20000) & 65535;
    if (v >= 32768) v -= 65536;
    return v;
  endfunction

  function automatic int model(int x, bit wrap, output string tag);
    int u, a, f, ta, tb, p;
    u  = x + 32768;
    a  = u / (1 << FW);
    f  = u % (1 << FW);
    ta = tval(a);
    if (a == L - 1) tb = wrap ? tval(0) : tval(L - 1);
    else tb = tval(a + 1);
    if (f == 0) tag = "R2";
    else if (a == L - 1) tag = wrap ? "R5" : "R4";
    else tag = "R3";
    p = f * (tb - ta) + (1 << (FW - 1));
    return ta + (p >>> FW);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, observe, model the coming rising edge.
  task automatic tick(bit v, int x, bit w, bit rdy);
    bit fin, fout;
    string tag;
    i_valid = v; i_x = DW'(x); i_wrap = w; o_ready = rdy;
    #1;
    cap_ov = o_valid;
    check(i_ready == (!o_valid || o_ready), "R8", int'(i_ready), int'(!o_valid || o_ready));
    if (prev_stall) begin
      check(o_valid && (o_y == prev_y), "R8", int'($signed(o_y)), int'($signed(prev_y)));
    end
    fin  = i_valid && i_ready;
    fout = o_valid && o_ready;
    if (fout) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6", int'($signed(o_y)), 0);
      end else begin
        int e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(int'($signed(o_y)) == e, t, int'($signed(o_y)), e);
      end
    end
    if (fin) begin
      expq.push_back(model(int'($signed(i_x)), i_wrap, tag));
      tagq.push_back(tag);
    end
    prev_stall = o_valid && !o_ready;
    prev_y = o_y;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(o_valid == 1'b0, "R9", int'(o_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(i_ready == 1'b1, "R9", int'(i_ready), 1);
    @(negedge clk);

    // R7: latency with the consumer always ready
    tick(1, 0, 0, 1);
    tick(0, 0, 0, 1); check(cap_ov == 1'b0, "R7", int'(cap_ov), 0);
    tick(0, 0, 0, 1); check(cap_ov == 1'b0, "R7", int'(cap_ov), 0);
    tick(0, 0, 0, 1); check(cap_ov == 1'b1, "R7", int'(cap_ov), 1);
    tick(0, 0, 0, 1);

    // Range ends and fraction corners: R1 R2 R3 R4 R5
    tick(1, -32768, 0, 1);
    tick(1, 32767, 0, 1);
    tick(1, 32767, 1, 1);
    tick(1, 32767 - 63, 0, 1);
    tick(1, 32767 - 63, 1, 1);
    tick(1, 32640, 1, 1);
    tick(1, 128, 0, 1);
    tick(1, 64, 0, 1);
    tick(1, -32768 + 64, 1, 1);
    tick(1, 1, 0, 1);
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 1);

    // Random traffic with back-pressure: R3 R6 R8
    for (int i = 0; i < 2000; i++) begin
      tick(($urandom % 4) != 0, int'($urandom % 65536) - 32768, $urandom % 2,
           ($urandom % 3) != 0);
    end

    for (int i = 0; i < 10; i++) tick(0, 0, 0, 1);
    check(expq.size() == 0, "R6", expq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule